// File: doc/BRIEF.md
# Transmit Timestamp Release Gate

This block sits on a 64-bit transmit sample stream between a memory-read engine and a sample unpacker. When the gate is enabled, every block on the stream opens with one 64-bit word that holds the time at which the block should go out, counted in sample clocks. The block data words follow that word. The gate takes that word off the stream and compares it with a free-running current-time input. It then does one of three things. It holds the block with back-pressure until that time comes due. It releases the block on the cycle the time is reached. It throws the whole block away if the time had already passed when the gate checked it.

The block length is a 32-bit configuration value that counts data words per block, not counting the time word. A length of zero turns the gate off, and the block then behaves as a wire between its input and output streams. While a block is held, the output data bus is driven to zero. A one-cycle late pulse lets software count underruns, and a stall level shows when the gate is holding.

The control is a five-state machine:
- ST_HDR takes the time word.
- ST_CHECK is the first decision cycle after the time word is captured.
- ST_HOLD waits for the time to come due.
- ST_PASS forwards the block.
- ST_DROP consumes the block and discards it.

The transitions are:
- HDR→CHECK when a time word is accepted.
- CHECK→DROP when the time is already past.
- CHECK→HOLD when the time is still ahead.
- CHECK→PASS or HOLD→PASS once it is due.
- CHECK or HOLD→HDR when it is due and a single-word block completes at once.
- PASS→HDR and DROP→HDR on the last data word.
- Any state→HDR while the length is zero.

Top module: `tx_sched_gate`

## Requirements
- R1: With blk_len equal to 0, the gate is a pass-through. m_data equals s_data, m_valid equals s_valid, s_ready equals m_ready, and late_pulse and stalled stay low.
- R2: With blk_len nonzero, the first word after enable and the word after each complete block is taken as a time word. It is accepted with s_ready high and never appears on the output.
- R3: The late check happens in the cycle after the time word is captured. If now_time is then strictly greater than the stored time, late_pulse is high for exactly that one cycle. All blk_len data words of the block are then accepted and discarded, and m_valid stays low.
- R4: While now_time is below the stored time, the gate holds the block. s_ready is low, m_valid is low, m_data is all zero, and stalled is high.
- R5: The gate forwards the block in the first cycle where now_time is greater than or equal to the stored time. If the first data word is already waiting and m_ready is high, that word leaves in the cycle where now_time equals the stored time.
- R6: After blk_len data words of a block have been accepted, the word counter returns to zero and the next word is treated as a time word.
- R7: The time comparison is unsigned. A stored time with bit 63 set is in the future for a current time with bit 63 clear.
- R8: During release, downstream back-pressure passes through, so s_ready follows m_ready and no data word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 64 | Input stream word (time word or sample data) |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high together with s_valid |
| m_data | output | 64 | Output sample word, zero while held |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| now_time | input | 64 | Current sample time |
| blk_len | input | 32 | Data words per block; 0 disables the gate |
| late_pulse | output | 1 | One-cycle pulse for each block dropped as late |
| stalled | output | 1 | High while a block is held waiting for its time |

## Verification
The bench targets the one-sample boundary of the late test. A time word equal to the current time in the capture cycle must be dropped, and one equal to the next time value must be released with no extra delay. An off-by-one compare would either lose the block or wait a cycle. A stored time with bit 63 set checks R7, because a signed compare would drop that block as late. Back-pressure during release and a late block followed by an on-time block check the word counter. A wrong counter would leak a time word into the output, or swallow a data word as a time word, and either shows up as a scoreboard mismatch. The zero-length case checks that the gate falls back to a plain wire, including the ready path.

// File: rtl/tx_sched_pkg.sv
`timescale 1ns/1ps
package tx_sched_pkg;
    typedef enum logic [2:0] {
        ST_HDR   = 3'd0,
        ST_CHECK = 3'd1,
        ST_HOLD  = 3'd2,
        ST_PASS  = 3'd3,
        ST_DROP  = 3'd4
    } gate_state_t;
endpackage

// File: rtl/tx_sched_word_cnt.sv
`timescale 1ns/1ps
// Counts data words inside a block; wraps to zero on the last word (R6).
module tx_sched_word_cnt #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [LEN_W-1:0] len,
    output logic             last
);
    localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    logic [LEN_W-1:0] cnt;

    assign last = (cnt == len - ONE);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + ONE;
        end
    end
endmodule

// File: rtl/tx_sched_time_cmp.sv
`timescale 1ns/1ps
// Holds the captured block time and compares it, unsigned, with the current time (R7).
module tx_sched_time_cmp #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TIME_W-1:0] ts_in,
    input  logic [TIME_W-1:0] now,
    output logic              due,
    output logic              late
);
    logic [TIME_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (load) begin
            ts_q <= ts_in;
        end
    end

    assign due  = (now >= ts_q);
    assign late = (now >  ts_q);
endmodule

// File: rtl/tx_sched_gate.sv
`timescale 1ns/1ps
module tx_sched_gate #(
    parameter int DATA_W = 64,
    parameter int TIME_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    input  logic [TIME_W-1:0] now_time,
    input  logic [LEN_W-1:0]  blk_len,
    output logic              late_pulse,
    output logic              stalled
);
    import tx_sched_pkg::*;

    gate_state_t state, nxt;
    logic        enabled;
    logic        xfer;
    logic        last;
    logic        due;
    logic        late;
    logic        cnt_clr;
    logic        cnt_inc;
    logic        ts_load;

    assign enabled = (blk_len != '0);
    assign xfer    = s_valid && s_ready;
    assign cnt_clr = !enabled || (state == ST_HDR);
    assign cnt_inc = enabled && xfer && (state != ST_HDR);
    assign ts_load = enabled && (state == ST_HDR) && s_valid;

    tx_sched_word_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .len   (blk_len),
        .last  (last)
    );

    tx_sched_time_cmp #(.TIME_W(TIME_W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ts_load),
        .ts_in (s_data[TIME_W-1:0]),
        .now   (now_time),
        .due   (due),
        .late  (late)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n || !enabled) begin
            state <= ST_HDR;
        end else begin
            state <= nxt;
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HDR:   if (s_valid) nxt = ST_CHECK;
            ST_CHECK: begin
                if (late)     nxt = ST_DROP;
                else if (due) nxt = (xfer && last) ? ST_HDR : ST_PASS;
                else          nxt = ST_HOLD;
            end
            ST_HOLD:  if (due) nxt = (xfer && last) ? ST_HDR : ST_PASS;
            ST_PASS:  if (xfer && last) nxt = ST_HDR;
            ST_DROP:  if (xfer && last) nxt = ST_HDR;
            default:  nxt = ST_HDR;
        endcase
    end

    // Outputs
    always_comb begin
        logic fwd;
        fwd        = 1'b0;
        s_ready    = 1'b0;
        m_data     = '0;
        m_valid    = 1'b0;
        late_pulse = 1'b0;
        stalled    = 1'b0;
        if (!enabled) begin
            m_data  = s_data;
            m_valid = s_valid;
            s_ready = m_ready;
        end else begin
            unique case (state)
                ST_HDR:   s_ready = 1'b1;
                ST_CHECK: begin
                    if (late)     late_pulse = 1'b1;
                    else if (due) fwd = 1'b1;
                    else          stalled = 1'b1;
                end
                ST_HOLD:  begin
                    if (due) fwd = 1'b1;
                    else     stalled = 1'b1;
                end
                ST_PASS:  fwd = 1'b1;
                ST_DROP:  s_ready = 1'b1;
                default:  s_ready = 1'b0;
            endcase
            if (fwd) begin
                m_data  = s_data;
                m_valid = s_valid;
                s_ready = m_ready;
            end
        end
    end
endmodule

// File: rtl/tx_sched_gate_chk.sv
`timescale 1ns/1ps
module tx_sched_gate_chk #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] s_data,
    input logic              s_valid,
    input logic              s_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic [LEN_W-1:0]  blk_len,
    input logic              late_pulse,
    input logic              stalled
);
    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_len == '0) |-> (m_data == s_data && m_valid == s_valid &&
                              s_ready == m_ready && !late_pulse && !stalled));

    assert_late_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        late_pulse |=> !late_pulse);

    assert_late_no_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        late_pulse |=> (!m_valid || blk_len == '0));

    assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!s_ready && !m_valid && m_data == '0));

    assert_ready_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (s_ready == m_ready));

    assert_status_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(late_pulse && stalled));
endmodule

bind tx_sched_gate tx_sched_gate_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .m_data     (m_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .blk_len    (blk_len),
    .late_pulse (late_pulse),
    .stalled    (stalled)
);

// File: tb/tx_sched_gate_test.sv
`timescale 1ns/1ps
module tx_sched_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [63:0] m_data;
    logic        m_valid;
    logic        m_ready;
    logic [63:0] now_time;
    logic [31:0] blk_len = '0;
    logic        late_pulse;
    logic        stalled;

    logic [63:0] time_base = 64'd1000;
    logic [63:0] tick = '0;
    logic        rdy_set = 1'b1;
    logic        bp_on = 1'b0;
    logic        bp_t = 1'b0;

    assign now_time = time_base + tick;
    assign m_ready  = bp_on ? bp_t : rdy_set;

    int checks = 0;
    int errors = 0;
    int late_seen = 0;
    int exp_late = 0;
    int stall_seen = 0;
    int cycles = 0;

    logic [63:0] exp_q[$];
    bit          first_q[$];
    logic [63:0] ts_q[$];
    bit          exact_q[$];

    tx_sched_gate uut (
        .clk(clk), .rst_n(rst_n), .s_data(s_data), .s_valid(s_valid),
        .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
        .m_ready(m_ready), .now_time(now_time), .blk_len(blk_len),
        .late_pulse(late_pulse), .stalled(stalled)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst_n) tick <= tick + 64'd1;
        bp_t <= ~bp_t;
        cycles <= cycles + 1;
    end

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (late_pulse) late_seen++;
            if (stalled) begin
                stall_seen++;
                chk(!s_ready && !m_valid && m_data == '0,
                    "R4 held block must stall with zero output",
                    {m_data[61:0], s_ready, m_valid}, 64'd0);
            end
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected output word", m_data, 64'd0);
                end else begin
                    logic [63:0] e;
                    bit f;
                    e = exp_q.pop_front();
                    f = first_q.pop_front();
                    chk(m_data == e, "R5/R8 scoreboard data", m_data, e);
                    if (f) begin
                        logic [63:0] t;
                        bit x;
                        t = ts_q.pop_front();
                        x = exact_q.pop_front();
                        chk(now_time >= t, "R5 released before due", now_time, t);
                        if (x) chk(now_time == t, "R5 release cycle", now_time, t);
                    end
                end
            end
        end
    end

    task automatic send_word(input logic [63:0] w);
        bit hs;
        s_data  = w;
        s_valid = 1'b1;
        do begin
            @(negedge clk);
            hs = s_ready;
            @(posedge clk);
            #1;
        end while (!hs);
        s_valid = 1'b0;
    endtask

    task automatic send_block(input logic [63:0] ts, input int n,
                              input logic [63:0] base, input bit exact);
        bit late;
        send_word(ts);
        late = (now_time > ts);
        if (late) begin
            exp_late++;
        end else begin
            for (int i = 0; i < n; i++) begin
                exp_q.push_back(base + 64'(i));
                first_q.push_back(i == 0);
            end
            ts_q.push_back(ts);
            exact_q.push_back(exact);
        end
        for (int i = 0; i < n; i++) send_word(base + 64'(i));
    endtask

    task automatic check_header_ready(input string what);
        @(negedge clk);
        chk(s_ready && !m_valid && !stalled, what,
            {61'd0, s_ready, m_valid, stalled}, 64'h4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!m_valid && !late_pulse && !stalled, "R1 reset state quiet",
            {61'd0, m_valid, late_pulse, stalled}, 64'd0);

        // R1: bypass, including ready path
        rdy_set = 1'b0;
        @(negedge clk);
        chk(s_ready == 1'b0, "R1 bypass ready low", {63'd0, s_ready}, 64'd0);
        rdy_set = 1'b1;
        @(negedge clk);
        chk(s_ready == 1'b1, "R1 bypass ready high", {63'd0, s_ready}, 64'd1);
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(64'hB0 + 64'(i));
            first_q.push_back(1'b0);
            send_word(64'hB0 + 64'(i));
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R1 bypass words delivered", exp_q.size(), 64'd0);

        // R2/R4/R5: on-time block, waits then releases exactly
        blk_len = 32'd4;
        @(posedge clk); #1;
        send_block(now_time + 64'd20, 4, 64'hA000, 1'b1);
        check_header_ready("R6 back to time word after block");

        // R3: late block (time equals now at capture, checked next cycle)
        @(posedge clk); #1;
        send_block(now_time, 4, 64'hD000, 1'b0);
        check_header_ready("R6 back to time word after dropped block");

        // R5 boundary: time equals now in the decision cycle, released at once
        @(posedge clk); #1;
        send_block(now_time + 64'd1, 4, 64'hC000, 1'b1);

        // R3: clearly late
        @(posedge clk); #1;
        send_block(now_time - 64'd5, 4, 64'hD100, 1'b0);

        // R8: back-pressure during release, new block length
        blk_len = 32'd6;
        @(posedge clk); #1;
        bp_on = 1'b1;
        send_block(now_time + 64'd8, 6, 64'hE000, 1'b0);
        repeat (6) @(posedge clk);
        bp_on = 1'b0;
        #1;

        // R7: unsigned compare across bit 63
        blk_len = 32'd2;
        @(posedge clk); #1;
        time_base = 64'h7FFF_FFFF_FFFF_FFF0 - tick;
        send_block(64'h8000_0000_0000_0004, 2, 64'hF000, 1'b1);

        // R2: single-word blocks back to back
        blk_len = 32'd1;
        @(posedge clk); #1;
        send_block(now_time + 64'd3, 1, 64'h1100, 1'b1);
        send_block(now_time + 64'd2, 1, 64'h1200, 1'b1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected words released", exp_q.size(), 64'd0);
        chk(late_seen == exp_late, "R3 late pulse count", late_seen, exp_late);
        chk(exp_late == 2, "R3 late blocks predicted", exp_late, 64'd2);
        chk(stall_seen > 0, "R4 hold observed", stall_seen, 64'd1);
        chk(!m_valid && s_ready, "R2 idle awaiting time word",
            {62'd0, m_valid, s_ready}, 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule